// File: doc/BRIEF.md
# Floating-point minimum/maximum unit

This block returns the smaller or the larger of two floating-point operands in half, single or double precision. Both operands come in as 64-bit register values. A half or single operand sits in the low bits with every bit above it set to one. The caller presents a format code, a min/max select and a valid strobe. One clock later the block returns a 64-bit result, boxed in the same way when the format is narrow, together with an invalid-operation flag.

Signed zeros are ordered with negative zero below positive zero. When exactly one operand is a NaN, the other operand is returned. When both are NaN, the canonical quiet NaN of the format is returned. A narrow operand that is not properly boxed counts as the canonical NaN. The invalid flag reports a signaling NaN on either input. The result and the flag stay registered until the next valid request.

Top module: `fminmax_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle in which `in_valid` was high. A synchronous active-high `rst` clears `out_valid` to 0.
- R2: While `in_valid` is low, `result` and `invalid_flag` keep their last values.
- R3: With `op_max`=0 (min), the result is operand `src_a` when it is numerically less than `src_b`, and `src_b` otherwise. Format codes: 5'h16 is half (sign bit 15), 5'h14 is single (sign bit 31) and 5'h15 is double (sign bit 63).
- R4: With `op_max`=1 (max), the result is `src_a` when `src_b` is numerically less than it, and `src_b` otherwise. Infinities order as the largest and smallest values.
- R5: Negative zero orders below positive zero in either operand order: min(+0,−0)=min(−0,+0)=−0 and max(+0,−0)=max(−0,+0)=+0.
- R6: When exactly one operand is a NaN, the result is the other operand.
- R7: When both operands are NaN, the result is the canonical NaN: 16'h7E00 for half, 32'h7FC00000 for single, 64'h7FF8000000000000 for double.
- R8: A half result has bits 63:16 set to one. A single result has bits 63:32 set to one.
- R9: A half or single operand whose bits above the format width are not all ones is treated as the canonical quiet NaN. Such an operand does not raise the invalid flag.
- R10: `invalid_flag` is 1 when either operand is a signaling NaN (exponent all ones, mantissa nonzero, mantissa MSB clear), and 0 for quiet NaNs and for numbers.
- R11: A format code other than 5'h16 or 5'h14 is handled as double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| fmt | input | 5 | Format code (5'h16 half, 5'h14 single, 5'h15 double) |
| op_max | input | 1 | 0 selects minimum, 1 selects maximum |
| src_a | input | 64 | First operand, boxed if narrow |
| src_b | input | 64 | Second operand, boxed if narrow |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Selected value, boxed if narrow |
| invalid_flag | output | 1 | Signaling NaN seen on an input |

## Verification
Ordinary numbers of mixed sign and of the same sign are tried in all three formats and in both operand orders. These cases separate the sign-first ordering from the reversed magnitude order of negative values. Zero pairs of opposite sign show whether the min and max tie-breaks pick the correct zero whichever side it is on. Single NaNs on each side, NaN pairs, signaling against quiet NaNs and badly boxed narrow inputs separate pass-through of the other operand from canonical NaN generation and from flag behaviour. Directed sequences check that a result appears one cycle after the strobe, is held while the strobe is low, and that reset clears the valid output.

// File: rtl/fminmax_unit.sv
module fminmax_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [4:0]  fmt,
  input  logic        op_max,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        invalid_flag
);

  localparam logic [4:0] FMT_HALF   = 5'h16;
  localparam logic [4:0] FMT_SINGLE = 5'h14;

  typedef enum logic [1:0] {K_H, K_S, K_D} kind_t;

  function automatic logic [63:0] canon(kind_t k);
    case (k)
      K_H:     canon = 64'h0000_0000_0000_7E00;
      K_S:     canon = 64'h0000_0000_7FC0_0000;
      default: canon = 64'h7FF8_0000_0000_0000;
    endcase
  endfunction

  function automatic logic [63:0] unbox(logic [63:0] v, kind_t k);
    case (k)
      K_H:     unbox = (&v[63:16]) ? {48'b0, v[15:0]} : canon(K_H);
      K_S:     unbox = (&v[63:32]) ? {32'b0, v[31:0]} : canon(K_S);
      default: unbox = v;
    endcase
  endfunction

  function automatic logic [63:0] align(logic [63:0] v, kind_t k);
    case (k)
      K_H:     align = {v[15:0], 48'b0};
      K_S:     align = {v[31:0], 32'b0};
      default: align = v;
    endcase
  endfunction

  function automatic logic [63:0] box(logic [63:0] v, kind_t k);
    case (k)
      K_H:     box = {48'hFFFF_FFFF_FFFF, v[15:0]};
      K_S:     box = {32'hFFFF_FFFF, v[31:0]};
      default: box = v;
    endcase
  endfunction

  function automatic logic is_nan(logic [63:0] v, kind_t k);
    case (k)
      K_H:     is_nan = (&v[14:10]) && (|v[9:0]);
      K_S:     is_nan = (&v[30:23]) && (|v[22:0]);
      default: is_nan = (&v[62:52]) && (|v[51:0]);
    endcase
  endfunction

  function automatic logic is_snan(logic [63:0] v, kind_t k);
    case (k)
      K_H:     is_snan = is_nan(v, k) && !v[9];
      K_S:     is_snan = is_nan(v, k) && !v[22];
      default: is_snan = is_nan(v, k) && !v[51];
    endcase
  endfunction

  kind_t       kind;
  logic [63:0] ua, ub, al_a, al_b, sel;
  logic        nan_a, nan_b, snan_any, ordered, both_zero, eq, lt_ab, lt_ba, pick_a;

  assign kind = (fmt == FMT_HALF) ? K_H : (fmt == FMT_SINGLE) ? K_S : K_D;

  assign ua    = unbox(src_a, kind);
  assign ub    = unbox(src_b, kind);
  assign al_a  = align(ua, kind);
  assign al_b  = align(ub, kind);
  assign nan_a = is_nan(ua, kind);
  assign nan_b = is_nan(ub, kind);
  assign snan_any = is_snan(ua, kind) || is_snan(ub, kind);

  assign ordered   = !nan_a && !nan_b;
  assign both_zero = (al_a[62:0] == '0) && (al_b[62:0] == '0);
  assign eq        = ordered && (both_zero || al_a == al_b);

  assign lt_ab = ordered && !both_zero &&
                 ((al_a[63] != al_b[63]) ? al_a[63] :
                  al_a[63] ? (al_a[62:0] > al_b[62:0]) : (al_a[62:0] < al_b[62:0]));
  assign lt_ba = ordered && !both_zero &&
                 ((al_a[63] != al_b[63]) ? al_b[63] :
                  al_b[63] ? (al_b[62:0] > al_a[62:0]) : (al_b[62:0] < al_a[62:0]));

  assign pick_a = nan_b || (op_max ? (lt_ba || (eq && al_b[63]))
                                   : (lt_ab || (eq && al_a[63])));

  assign sel = (nan_a && nan_b) ? canon(kind) : (pick_a ? ua : ub);

  kind_t kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      invalid_flag <= 1'b0;
      kind_q       <= K_D;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= box(sel, kind);
        invalid_flag <= snan_any;
        kind_q       <= kind;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(invalid_flag));
  a_r6_other_operand: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nan_b && !nan_a) |=> result == $past(box(ua, kind)));
  a_r7_canonical: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nan_a && nan_b) |=> result == $past(box(canon(kind), kind)));
  a_r8_box_half: assert property (@(posedge clk) disable iff (rst)
    (out_valid && kind_q == K_H) |-> (&result[63:16]));
  a_r8_box_single: assert property (@(posedge clk) disable iff (rst)
    (out_valid && kind_q == K_S) |-> (&result[63:32]));
  a_r10_quiet_no_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_snan(src_a, K_D) && !is_snan(src_b, K_D) && kind == K_D) |=> !invalid_flag);

endmodule

// File: tb/fminmax_unit_tb.sv
`timescale 1ns/1ps
module fminmax_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  fmt = 5'h15;
  logic        op_max = 1'b0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fminmax_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt), .op_max(op_max),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
    .invalid_flag(invalid_flag)
  );

  localparam logic [4:0] H = 5'h16, S = 5'h14, D = 5'h15;
  localparam int NV = 32;
  // {fmt, op_max, src_a, src_b, expected result, expected flag, requirement number}
  localparam logic [202:0] VEC [NV] = '{
    {S, 1'b0, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_40000000, 64'hFFFFFFFF_3F800000, 1'b0, 4'd3},  // R3
    {S, 1'b0, 64'hFFFFFFFF_40000000, 64'hFFFFFFFF_BF800000, 64'hFFFFFFFF_BF800000, 1'b0, 4'd3},  // R3
    {S, 1'b0, 64'hFFFFFFFF_BF800000, 64'hFFFFFFFF_C0000000, 64'hFFFFFFFF_C0000000, 1'b0, 4'd3},  // R3
    {D, 1'b0, 64'h4008000000000000, 64'hC008000000000000, 64'hC008000000000000, 1'b0, 4'd3},     // R3
    {H, 1'b0, 64'hFFFFFFFFFFFF4000, 64'hFFFFFFFFFFFFC000, 64'hFFFFFFFFFFFFC000, 1'b0, 4'd3},     // R3
    {S, 1'b1, 64'hFFFFFFFF_BF800000, 64'hFFFFFFFF_C0000000, 64'hFFFFFFFF_BF800000, 1'b0, 4'd4},  // R4
    {S, 1'b1, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_40000000, 64'hFFFFFFFF_40000000, 1'b0, 4'd4},  // R4
    {D, 1'b1, 64'hC008000000000000, 64'h3FF0000000000000, 64'h3FF0000000000000, 1'b0, 4'd4},     // R4
    {H, 1'b1, 64'hFFFFFFFFFFFF3C00, 64'hFFFFFFFFFFFF4000, 64'hFFFFFFFFFFFF4000, 1'b0, 4'd4},     // R4
    {H, 1'b1, 64'hFFFFFFFFFFFF7C00, 64'hFFFFFFFFFFFFFC00, 64'hFFFFFFFFFFFF7C00, 1'b0, 4'd4},     // R4
    {S, 1'b0, 64'hFFFFFFFF_00000000, 64'hFFFFFFFF_80000000, 64'hFFFFFFFF_80000000, 1'b0, 4'd5},  // R5
    {S, 1'b0, 64'hFFFFFFFF_80000000, 64'hFFFFFFFF_00000000, 64'hFFFFFFFF_80000000, 1'b0, 4'd5},  // R5
    {S, 1'b1, 64'hFFFFFFFF_80000000, 64'hFFFFFFFF_00000000, 64'hFFFFFFFF_00000000, 1'b0, 4'd5},  // R5
    {S, 1'b1, 64'hFFFFFFFF_00000000, 64'hFFFFFFFF_80000000, 64'hFFFFFFFF_00000000, 1'b0, 4'd5},  // R5
    {D, 1'b0, 64'h8000000000000000, 64'h0000000000000000, 64'h8000000000000000, 1'b0, 4'd5},     // R5
    {H, 1'b1, 64'hFFFFFFFFFFFF0000, 64'hFFFFFFFFFFFF8000, 64'hFFFFFFFFFFFF0000, 1'b0, 4'd5},     // R5
    {S, 1'b0, 64'hFFFFFFFF_7FC12345, 64'hFFFFFFFF_40000000, 64'hFFFFFFFF_40000000, 1'b0, 4'd6},  // R6
    {S, 1'b1, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_7FC12345, 64'hFFFFFFFF_3F800000, 1'b0, 4'd6},  // R6
    {D, 1'b0, 64'h7FF8000000000001, 64'h4008000000000000, 64'h4008000000000000, 1'b0, 4'd6},     // R6
    {S, 1'b0, 64'hFFFFFFFF_7FC12345, 64'hFFFFFFFF_FFC00000, 64'hFFFFFFFF_7FC00000, 1'b0, 4'd7},  // R7
    {H, 1'b1, 64'hFFFFFFFFFFFF7E01, 64'hFFFFFFFFFFFFFE00, 64'hFFFFFFFFFFFF7E00, 1'b0, 4'd7},     // R7
    {D, 1'b0, 64'h7FF8000000000001, 64'hFFF8000000000000, 64'h7FF8000000000000, 1'b0, 4'd7},     // R7
    {H, 1'b0, 64'hFFFFFFFFFFFFC000, 64'hFFFFFFFFFFFF3C00, 64'hFFFFFFFFFFFFC000, 1'b0, 4'd8},     // R8
    {S, 1'b1, 64'hFFFFFFFF_00000000, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_3F800000, 1'b0, 4'd8},  // R8
    {S, 1'b0, 64'h00000000_3F800000, 64'hFFFFFFFF_40000000, 64'hFFFFFFFF_40000000, 1'b0, 4'd9},  // R9
    {H, 1'b1, 64'h0000000000003C00, 64'hFFFFFFFF00004000, 64'hFFFFFFFFFFFF7E00, 1'b0, 4'd9},     // R9
    {S, 1'b0, 64'h00000000_7F800001, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_3F800000, 1'b0, 4'd9},  // R9
    {S, 1'b0, 64'hFFFFFFFF_7F800001, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_3F800000, 1'b1, 4'd10}, // R10
    {D, 1'b1, 64'h4008000000000000, 64'h7FF0000000000001, 64'h4008000000000000, 1'b1, 4'd10},    // R10
    {H, 1'b0, 64'hFFFFFFFFFFFF7C01, 64'hFFFFFFFFFFFF7D00, 64'hFFFFFFFFFFFF7E00, 1'b1, 4'd10},    // R10
    {D, 1'b0, 64'h7FF8000000000000, 64'h7FF8000000000005, 64'h7FF8000000000000, 1'b0, 4'd10},    // R10
    {5'h00, 1'b0, 64'h4008000000000000, 64'hC008000000000000, 64'hC008000000000000, 1'b0, 4'd11} // R11
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [4:0] f, logic op, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    fmt = f; op_max = op; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'b0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle valid", {63'b0, out_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [202:0] v;
      v = VEC[i];
      issue(v[202:198], v[197], v[196:133], v[132:69]);
      check($sformatf("R%0d vec %0d result", v[3:0], i), result, v[68:5]);
      check($sformatf("R%0d vec %0d flag", v[3:0], i), {63'b0, invalid_flag}, {63'b0, v[4]});
      check("R1 valid after strobe", {63'b0, out_valid}, 64'd1);
    end

    issue(S, 1'b1, 64'hFFFFFFFF_7F800001, 64'hFFFFFFFF_40000000);
    fmt = D; src_a = 64'h0; src_b = 64'h3FF0000000000000; op_max = 1'b0;
    @(negedge clk);
    check("R1 valid drops", {63'b0, out_valid}, 64'd0);
    check("R2 result held", result, 64'hFFFFFFFF_40000000);
    check("R2 flag held", {63'b0, invalid_flag}, 64'd1);
    repeat (3) @(negedge clk);
    check("R2 result held later", result, 64'hFFFFFFFF_40000000);

    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 reset beats strobe", {63'b0, out_valid}, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {63'b0, out_valid}, 64'd0);

    @(negedge clk);
    fmt = D; op_max = 1'b1; src_a = 64'h3FF0000000000000; src_b = 64'h4008000000000000; in_valid = 1'b1;
    @(negedge clk);
    check("R4 back-to-back first", result, 64'h4008000000000000);
    op_max = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 back-to-back second", result, 64'h3FF0000000000000);
    check("R1 valid on second", {63'b0, out_valid}, 64'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule